// File: doc/BRIEF.md
# Capture-Compare Timer with DMA Handoff

A 16-bit free-running timer with one input-capture channel and one output-compare channel. A rising edge on the capture input stores the counter value in the capture register. When the counter equals the compare register, the compare pin toggles. Each channel event goes to one of two places, chosen by that channel's DMA enable bit in the mode register. With the bit clear, the event raises a one-cycle interrupt pulse. With the bit set, it raises a DMA request that an external arbiter serves.

Each channel has its own transfer address and transfer count. On a capture transfer the block presents the captured value and the current address. On a compare transfer it loads the compare register from the data returned by the arbiter. Both kinds of transfer step the address by 2 and lower the count by one. When the count runs out, the block sends an end-of-block pulse tagged with a requester ID. The ID is formed as {instance ID, channel}, with channel 0 for capture and channel 1 for compare. The arbiter returns end-of-block pulses to every timer instance on a shared return path. Each instance drops the DMA enable bit only when the returned ID is its own, so an end-of-block meant for a different instance or channel leaves this one's mode and pending transfer untouched.

Top module: `capcmp_timer`

## Requirements
- R1: The counter advances by 1 every clock and wraps from 0xFFFF to 0x0000. A write to register address 0 loads it, and it continues counting from the written value.
- R2: A rising edge on `capIn`, seen at a clock edge where the previous sample was 0, stores the counter value of that cycle in the capture register (address 1, read only).
- R3: In each cycle where the counter equals the compare register (address 2, reset value 0xFFFF), `cmpOut` toggles at the next clock edge.
- R4: Mode register (address 3): bit 6 enables DMA for capture and bit 3 enables DMA for compare. Both reset to 0. A channel event with its bit clear gives a one-cycle pulse on `capIrq` or `cmpIrq` and no request. With the bit set it gives a request and no pulse.
- R5: `dmaReq[0]` (capture) and `dmaReq[1]` (compare) stay high until the matching `dmaAck` bit is seen while the request is high. An acknowledge with no request pending changes no state. At most one acknowledge bit is high at a time.
- R6: During a capture acknowledge, `dmaWdata` carries the capture register and `dmaAddr` carries the capture address (address 4). After the transfer the address has grown by 2 and the capture count (address 5) has dropped by 1. A count of 0 stays at 0.
- R7: A compare transfer loads the compare register from `dmaRdata`. `dmaAddr` carries the compare address (address 6), which then grows by 2, and the compare count (address 7) drops by 1.
- R8: A transfer that starts with a count of 1 or 0 drives `eobOut` high for the next cycle, with `eobOutId` = {INST_ID, channel}.
- R9: `eobIn` clears capture DMA enable only when `eobInId` = {INST_ID, 0`b0`}, and clears compare DMA enable only when `eobInId` = {INST_ID, 1`b1`}. Any other ID leaves both bits and any pending request unchanged. A clear wins over a mode write in the same cycle.
- R10: A capture edge while a capture request is pending and not being acknowledged sets the overrun flag (mode bit 0). Writing the mode register with bit 0 = 1 clears the flag.
- R11: `regRdata` returns, for the address on `regAddr` and in the same cycle: counter, capture, compare, mode, capture address, capture count, compare address, compare count, at addresses 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for both read and write |
| regWdata | input | CNT_W | Register write data |
| regRdata | output | CNT_W | Read data for regAddr, combinational |
| capIn | input | 1 | External capture event input |
| cmpOut | output | 1 | Compare output pin |
| capIrq | output | 1 | Capture interrupt pulse |
| cmpIrq | output | 1 | Compare interrupt pulse |
| dmaReq | output | 2 | Transfer requests: bit 0 capture, bit 1 compare |
| dmaAck | input | 2 | Transfer acknowledges from the arbiter |
| dmaAddr | output | CNT_W | Address of the acknowledged transfer |
| dmaWdata | output | CNT_W | Captured value to be written to memory |
| dmaRdata | input | CNT_W | Memory data for a compare transfer |
| eobOut | output | 1 | End-of-block raised by this block |
| eobOutId | output | INST_W+1 | Requester ID of eobOut |
| eobIn | input | 1 | End-of-block returned from the arbiter |
| eobInId | input | INST_W+1 | Requester ID of eobIn |

## Verification
The assertions check these properties on every cycle: a channel event never gives both an interrupt pulse and a request, a request holds until it is acknowledged, every end-of-block follows an acknowledge, and a returned end-of-block with a foreign ID never drops an enable bit. They also check that the counter steps by one and that each transfer steps its address and loads the compare register. Only the bench's scenarios can show the rest: the full DMA handoff across several transfers, the return to interrupt mode through the looped-back end-of-block, the behaviour with a zero count, overrun and its clear, and foreign end-of-block pulses from instance 0 and from this instance's other channel arriving while a capture request waits.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [2:0] ADR_CNT    = 3'd0;
  localparam logic [2:0] ADR_CAP    = 3'd1;
  localparam logic [2:0] ADR_CMP    = 3'd2;
  localparam logic [2:0] ADR_MODE   = 3'd3;
  localparam logic [2:0] ADR_CAPADR = 3'd4;
  localparam logic [2:0] ADR_CAPLEN = 3'd5;
  localparam logic [2:0] ADR_CMPADR = 3'd6;
  localparam logic [2:0] ADR_CMPLEN = 3'd7;

  localparam int CAP_DMA_BIT = 6;
  localparam int CMP_DMA_BIT = 3;
  localparam int OVR_BIT     = 0;

  typedef struct packed {
    logic capLatch;
    logic cmpToggle;
    logic capXfer;
    logic cmpXfer;
  } strobe_t;
endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic [CNT_W-1:0] dmaRdata,
  output logic [CNT_W-1:0] counter,
  output logic [CNT_W-1:0] capReg,
  output logic [CNT_W-1:0] cmpReg,
  output logic [CNT_W-1:0] capAddr,
  output logic [CNT_W-1:0] capLen,
  output logic [CNT_W-1:0] cmpAddr,
  output logic [CNT_W-1:0] cmpLen,
  output logic             cmpOut,
  output logic             cmpMatch,
  output logic             capLenLast,
  output logic             cmpLenLast
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ZERO  = '0;
  localparam logic [CNT_W-1:0] CMP_RST = '1;

  logic wrCnt, wrCmp, wrCapAdr, wrCapLen, wrCmpAdr, wrCmpLen;

  assign wrCnt    = regWe && (regAddr == ADR_CNT);
  assign wrCmp    = regWe && (regAddr == ADR_CMP);
  assign wrCapAdr = regWe && (regAddr == ADR_CAPADR);
  assign wrCapLen = regWe && (regAddr == ADR_CAPLEN);
  assign wrCmpAdr = regWe && (regAddr == ADR_CMPADR);
  assign wrCmpLen = regWe && (regAddr == ADR_CMPLEN);

  assign cmpMatch   = (counter == cmpReg);
  assign capLenLast = (capLen <= ONE);
  assign cmpLenLast = (cmpLen <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter <= ZERO;
      capReg  <= ZERO;
      cmpReg  <= CMP_RST;
      cmpOut  <= 1'b0;
    end else begin
      counter <= wrCnt ? regWdata : counter + ONE;
      if (strobe.capLatch) capReg <= counter;
      if (strobe.cmpXfer)  cmpReg <= dmaRdata;
      else if (wrCmp)      cmpReg <= regWdata;
      if (strobe.cmpToggle) cmpOut <= ~cmpOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= ZERO;
      capLen  <= ZERO;
      cmpAddr <= ZERO;
      cmpLen  <= ZERO;
    end else begin
      if (strobe.capXfer) begin
        capAddr <= capAddr + STEP;
        capLen  <= (capLen == ZERO) ? ZERO : capLen - ONE;
      end else begin
        if (wrCapAdr) capAddr <= regWdata;
        if (wrCapLen) capLen  <= regWdata;
      end
      if (strobe.cmpXfer) begin
        cmpAddr <= cmpAddr + STEP;
        cmpLen  <= (cmpLen == ZERO) ? ZERO : cmpLen - ONE;
      end else begin
        if (wrCmpAdr) cmpAddr <= regWdata;
        if (wrCmpLen) cmpLen  <= regWdata;
      end
    end
  end

  // R1: free-running count unless loaded
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !wrCnt |=> counter == $past(counter) + ONE);

  // R6: capture transfer steps its address
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capXfer |=> capAddr == $past(capAddr) + STEP);

  // R7: compare transfer loads the compare register from memory data
  a_r7_cmp_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpXfer |=> cmpReg == $past(dmaRdata));
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int INST_W = 2,
  parameter logic [INST_W-1:0] INST_ID = '0,
  localparam int ID_W = INST_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            capIn,
  input  logic            modeWr,
  input  logic            modeCapBit,
  input  logic            modeCmpBit,
  input  logic            modeOvrClr,
  input  logic            cmpMatch,
  input  logic            capLenLast,
  input  logic            cmpLenLast,
  input  logic [1:0]      dmaAck,
  input  logic            eobIn,
  input  logic [ID_W-1:0] eobInId,
  output strobe_t         strobe,
  output logic            capDma,
  output logic            cmpDma,
  output logic            overrun,
  output logic [1:0]      dmaReq,
  output logic            capIrq,
  output logic            cmpIrq,
  output logic            eobOut,
  output logic [ID_W-1:0] eobOutId
);
  localparam logic [ID_W-1:0] CAP_ID = {INST_ID, 1'b0};
  localparam logic [ID_W-1:0] CMP_ID = {INST_ID, 1'b1};

  logic capInQ, capEdge, capXfer, cmpXfer, capEobHit, cmpEobHit;
  logic eobCap, eobCmp;

  assign capEdge   = capIn & ~capInQ;
  assign capXfer   = dmaAck[0] & dmaReq[0];
  assign cmpXfer   = dmaAck[1] & dmaReq[1];
  assign capEobHit = capXfer & capLenLast;
  assign cmpEobHit = cmpXfer & cmpLenLast;
  assign eobCap    = eobIn && (eobInId == CAP_ID);
  assign eobCmp    = eobIn && (eobInId == CMP_ID);

  always_comb begin
    strobe.capLatch  = capEdge;
    strobe.cmpToggle = cmpMatch;
    strobe.capXfer   = capXfer;
    strobe.cmpXfer   = cmpXfer;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capInQ   <= 1'b0;
      capDma   <= 1'b0;
      cmpDma   <= 1'b0;
      overrun  <= 1'b0;
      dmaReq   <= 2'b00;
      capIrq   <= 1'b0;
      cmpIrq   <= 1'b0;
      eobOut   <= 1'b0;
      eobOutId <= '0;
    end else begin
      capInQ    <= capIn;
      capIrq    <= capEdge & ~capDma;
      cmpIrq    <= cmpMatch & ~cmpDma;
      dmaReq[0] <= (capEdge & capDma) | (dmaReq[0] & ~dmaAck[0]);
      dmaReq[1] <= (cmpMatch & cmpDma) | (dmaReq[1] & ~dmaAck[1]);
      if (capEdge & capDma & dmaReq[0] & ~dmaAck[0]) overrun <= 1'b1;
      else if (modeWr & modeOvrClr)                  overrun <= 1'b0;
      if (eobCap)      capDma <= 1'b0;
      else if (modeWr) capDma <= modeCapBit;
      if (eobCmp)      cmpDma <= 1'b0;
      else if (modeWr) cmpDma <= modeCmpBit;
      eobOut   <= capEobHit | cmpEobHit;
      eobOutId <= {INST_ID, cmpEobHit};
    end
  end

  // R4: an event never yields both an interrupt pulse and a request
  a_r4_irq_or_req: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> !$rose(dmaReq[0]));
  // R5: pending request holds until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq[0] && !dmaAck[0] |=> dmaReq[0]);
  // R5: the arbiter acknowledges one channel at a time
  a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dmaAck));
  // R8: end-of-block only follows an acknowledge
  a_r8_eob_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eobOut) |-> $past(|dmaAck));
  // R9: foreign end-of-block keeps the capture enable
  a_r9_foreign_keeps: assert property (@(posedge clk) disable iff (!rstN)
    eobIn && (eobInId != CAP_ID) && capDma && !modeWr |=> capDma);
  // R10: capture over a waiting request flags overrun
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    capEdge && capDma && dmaReq[0] && !dmaAck[0] |=> overrun);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int INST_W = 2,
  parameter logic [INST_W-1:0] INST_ID = '0,
  localparam int ID_W = INST_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  input  logic             capIn,
  output logic             cmpOut,
  output logic             capIrq,
  output logic             cmpIrq,
  output logic [1:0]       dmaReq,
  input  logic [1:0]       dmaAck,
  output logic [CNT_W-1:0] dmaAddr,
  output logic [CNT_W-1:0] dmaWdata,
  input  logic [CNT_W-1:0] dmaRdata,
  output logic             eobOut,
  output logic [ID_W-1:0]  eobOutId,
  input  logic             eobIn,
  input  logic [ID_W-1:0]  eobInId
);
  strobe_t strobe;
  logic [CNT_W-1:0] counter, capReg, cmpReg, capAddr, capLen, cmpAddr, cmpLen;
  logic [CNT_W-1:0] modeWord;
  logic cmpMatch, capLenLast, cmpLenLast, capDma, cmpDma, overrun, modeWr;

  assign modeWr = regWe && (regAddr == ADR_MODE);

  capcmp_ctrl #(.INST_W(INST_W), .INST_ID(INST_ID)) ctrl (
    .clk(clk), .rstN(rstN), .capIn(capIn),
    .modeWr(modeWr), .modeCapBit(regWdata[CAP_DMA_BIT]),
    .modeCmpBit(regWdata[CMP_DMA_BIT]), .modeOvrClr(regWdata[OVR_BIT]),
    .cmpMatch(cmpMatch), .capLenLast(capLenLast), .cmpLenLast(cmpLenLast),
    .dmaAck(dmaAck), .eobIn(eobIn), .eobInId(eobInId),
    .strobe(strobe), .capDma(capDma), .cmpDma(cmpDma), .overrun(overrun),
    .dmaReq(dmaReq), .capIrq(capIrq), .cmpIrq(cmpIrq),
    .eobOut(eobOut), .eobOutId(eobOutId)
  );

  capcmp_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .dmaRdata(dmaRdata),
    .counter(counter), .capReg(capReg), .cmpReg(cmpReg),
    .capAddr(capAddr), .capLen(capLen), .cmpAddr(cmpAddr), .cmpLen(cmpLen),
    .cmpOut(cmpOut), .cmpMatch(cmpMatch),
    .capLenLast(capLenLast), .cmpLenLast(cmpLenLast)
  );

  always_comb begin
    modeWord = '0;
    modeWord[CAP_DMA_BIT] = capDma;
    modeWord[CMP_DMA_BIT] = cmpDma;
    modeWord[OVR_BIT]     = overrun;
  end

  always_comb begin
    case (regAddr)
      ADR_CNT:    regRdata = counter;
      ADR_CAP:    regRdata = capReg;
      ADR_CMP:    regRdata = cmpReg;
      ADR_MODE:   regRdata = modeWord;
      ADR_CAPADR: regRdata = capAddr;
      ADR_CAPLEN: regRdata = capLen;
      ADR_CMPADR: regRdata = cmpAddr;
      default:    regRdata = cmpLen;
    endcase
  end

  assign dmaAddr  = dmaAck[1] ? cmpAddr : capAddr;
  assign dmaWdata = capReg;
endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] INST = 2'd1;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0, capIn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWdata = '0, dmaRdata = '0;
  logic [1:0] dmaAck = 2'b00, ackFrc = 2'b00;
  logic ackEn = 1'b1, loopEn = 1'b1, eobFrc = 1'b0;
  logic [2:0] eobFrcId = 3'd0;
  logic [15:0] regRdata, dmaAddr, dmaWdata;
  logic cmpOut, capIrq, cmpIrq, eobOut, eobIn;
  logic [1:0] dmaReq;
  logic [2:0] eobOutId, eobInId;
  int errors = 0, checks = 0;
  logic [2:0] rdPtr = 3'd0;

  always #(PERIOD/2) clk = ~clk;

  assign eobIn   = loopEn ? eobOut : eobFrc;
  assign eobInId = loopEn ? eobOutId : eobFrcId;

  capcmp_timer #(.CNT_W(16), .INST_W(2), .INST_ID(INST)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .capIn(capIn), .cmpOut(cmpOut),
    .capIrq(capIrq), .cmpIrq(cmpIrq), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaRdata(dmaRdata),
    .eobOut(eobOut), .eobOutId(eobOutId), .eobIn(eobIn), .eobInId(eobInId)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] mCnt, mCap, mCmp, mCapA, mCapL, mCmpA, mCmpL;
  logic mOut, mCapDma, mCmpDma, mOvr, mCapIrq, mCmpIrq, mEob, mCapQ;
  logic [1:0] mReq;
  logic [2:0] mEobId;

  always @(posedge clk) begin
    logic edgeC, hit, wrMode, cX, kX, cEob, kEob;
    if (!rstN) begin
      mCnt = 0; mCap = 0; mCmp = 16'hFFFF; mCapA = 0; mCapL = 0; mCmpA = 0; mCmpL = 0;
      mOut = 0; mCapDma = 0; mCmpDma = 0; mOvr = 0; mCapIrq = 0; mCmpIrq = 0;
      mEob = 0; mCapQ = 0; mReq = 0; mEobId = 0;
    end else begin
      edgeC  = capIn && !mCapQ;
      hit    = (mCnt == mCmp);
      wrMode = regWe && regAddr == 3'd3;
      cX = dmaAck[0] && mReq[0];
      kX = dmaAck[1] && mReq[1];
      cEob = cX && (mCapL == 0 || mCapL == 1);
      kEob = kX && (mCmpL == 0 || mCmpL == 1);
      mCapIrq = edgeC && !mCapDma;
      mCmpIrq = hit && !mCmpDma;
      if (edgeC && mCapDma && mReq[0] && !dmaAck[0]) mOvr = 1;
      else if (wrMode && regWdata[0]) mOvr = 0;
      mReq[0] = (edgeC && mCapDma) || (mReq[0] && !dmaAck[0]);
      mReq[1] = (hit && mCmpDma) || (mReq[1] && !dmaAck[1]);
      if (eobIn && eobInId == {INST, 1'b0}) mCapDma = 0;
      else if (wrMode) mCapDma = regWdata[6];
      if (eobIn && eobInId == {INST, 1'b1}) mCmpDma = 0;
      else if (wrMode) mCmpDma = regWdata[3];
      mEob = cEob || kEob;
      mEobId = {INST, kEob};
      if (edgeC) mCap = mCnt;
      if (hit) mOut = !mOut;
      if (kX) mCmp = dmaRdata;
      else if (regWe && regAddr == 3'd2) mCmp = regWdata;
      mCnt = (regWe && regAddr == 3'd0) ? regWdata : mCnt + 16'd1;
      if (cX) begin mCapA = mCapA + 2; if (mCapL != 0) mCapL = mCapL - 1; end
      else begin
        if (regWe && regAddr == 3'd4) mCapA = regWdata;
        if (regWe && regAddr == 3'd5) mCapL = regWdata;
      end
      if (kX) begin mCmpA = mCmpA + 2; if (mCmpL != 0) mCmpL = mCmpL - 1; end
      else begin
        if (regWe && regAddr == 3'd6) mCmpA = regWdata;
        if (regWe && regAddr == 3'd7) mCmpL = regWdata;
      end
      mCapQ = capIn;
    end
  end

  function automatic logic [15:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCnt;
      3'd1: return mCap;
      3'd2: return mCmp;
      3'd3: return {9'd0, mCapDma, 2'd0, mCmpDma, 2'd0, mOvr};
      3'd4: return mCapA;
      3'd5: return mCapL;
      3'd6: return mCmpA;
      default: return mCmpL;
    endcase
  endfunction

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      chk("R11 regRdata", regRdata, mRead(regAddr));
      chk("R3 cmpOut", cmpOut, mOut);
      chk("R4 capIrq", capIrq, mCapIrq);
      chk("R4 cmpIrq", cmpIrq, mCmpIrq);
      chk("R5 dmaReq", dmaReq, mReq);
      chk("R6 dmaAddr", dmaAddr, dmaAck[1] ? mCmpA : mCapA);
      chk("R6 dmaWdata", dmaWdata, mCap);
      chk("R8 eobOut", eobOut, mEob);
      chk("R8 eobOutId", eobOutId, mEobId);
    end
  end

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic cap);
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = d; capIn = cap;
    dmaAck = ackFrc;
    if (ackEn && ackFrc == 2'b00) begin
      if (dmaReq[0]) dmaAck = 2'b01;
      else if (dmaReq[1]) dmaAck = 2'b10;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, rdPtr, 16'd0, 1'b0);
      rdPtr = rdPtr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    step(1'b0, a, 16'd0, 1'b0);
    #1 v = regRdata;
  endtask

  task automatic capPulse();
    step(1'b0, 3'd0, 16'd0, 1'b1);
    step(1'b0, 3'd0, 16'd0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, v0;
    logic pinBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    rd(3'd3, v); chk("R4 mode after reset", v, 16'h0000);
    rd(3'd2, v); chk("R11 compare after reset", v, 16'hFFFF);
    rd(3'd5, v); chk("R6 capture count after reset", v, 16'h0000);
    // R1 load and wrap
    wr(3'd0, 16'hFFFE);
    rd(3'd0, v); chk("R1 load", v, 16'hFFFE);
    rd(3'd0, v); chk("R1 step", v, 16'hFFFF);
    rd(3'd0, v); chk("R1 wrap", v, 16'h0000);
    idle(3);
    // R2 capture in interrupt mode
    rd(3'd0, v0);
    capPulse();
    rd(3'd1, v); chk("R2 captured value", v, v0 + 16'd1);
    idle(3);
    // R3 compare toggles pin, interrupt mode
    pinBefore = cmpOut;
    wr(3'd2, mCnt + 16'd4);
    idle(8);
    chk("R3 pin toggled", cmpOut, !pinBefore);
    // R6/R8/R9 capture DMA, end-of-block looped back
    wr(3'd4, 16'h0100); wr(3'd5, 16'd2); wr(3'd3, 16'h0040);
    capPulse(); idle(3);
    rd(3'd3, v); chk("R4 capture DMA still on", v, 16'h0040);
    capPulse(); idle(4);
    rd(3'd3, v); chk("R9 own end-of-block clears capture DMA", v, 16'h0000);
    rd(3'd4, v); chk("R6 capture address advanced", v, 16'h0104);
    rd(3'd5, v); chk("R6 capture count spent", v, 16'h0000);
    // R9 foreign end-of-block while a request waits
    ackEn = 1'b0; loopEn = 1'b0;
    wr(3'd5, 16'd5); wr(3'd3, 16'h0040);
    capPulse(); idle(2);
    eobFrc = 1'b1; eobFrcId = 3'b000; idle(1);
    eobFrcId = 3'b011; idle(1);
    eobFrc = 1'b0;
    rd(3'd3, v); chk("R9 foreign ID keeps capture DMA", v, 16'h0040);
    chk("R9 request kept pending", dmaReq[0], 1'b1);
    ackEn = 1'b1; idle(3);
    chk("R5 request served", dmaReq[0], 1'b0);
    rd(3'd5, v); chk("R6 count decremented", v, 16'd4);
    // R10 overrun
    ackEn = 1'b0;
    capPulse(); idle(1); capPulse(); idle(1);
    rd(3'd3, v); chk("R10 overrun set", v, 16'h0041);
    wr(3'd3, 16'h0041);
    rd(3'd3, v); chk("R10 overrun cleared", v, 16'h0040);
    ackEn = 1'b1; idle(3);
    // R8 zero count ends block on first transfer
    loopEn = 1'b1;
    wr(3'd5, 16'd0);
    capPulse(); idle(4);
    rd(3'd3, v); chk("R8 zero count ends block", v, 16'h0000);
    // R7 compare DMA
    dmaRdata = 16'h0040;
    wr(3'd6, 16'h0200); wr(3'd7, 16'd1); wr(3'd3, 16'h0008);
    wr(3'd2, mCnt + 16'd4);
    idle(8);
    rd(3'd2, v); chk("R7 compare loaded from memory", v, 16'h0040);
    rd(3'd3, v); chk("R8 compare DMA ended", v, 16'h0000);
    rd(3'd6, v); chk("R7 compare address advanced", v, 16'h0202);
    // R5 acknowledge without request
    dmaRdata = 16'h1234;
    ackFrc = 2'b10; idle(1); ackFrc = 2'b00;
    rd(3'd6, v); chk("R5 stray ack leaves address", v, 16'h0202);
    rd(3'd2, v); chk("R5 stray ack leaves compare", v, 16'h0040);
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule